// File: doc/BRIEF.md
# Breakpoint-table sensor code to temperature converter

This block turns a raw thermal-sensor code into a temperature in signed millidegrees. It holds a small table of breakpoints, each a (code, temperature) pair, built at elaboration from parameters. The temperatures rise in equal steps and the codes move monotonically, either upward or downward depending on the sensor. A request carries one code. The block finds the table segment that brackets the code with a binary search that tests one midpoint per clock. It then interpolates linearly inside that segment, using one multi-cycle restoring division. The block answers with the temperature, or with an error flag when no segment holds the code.

The same request port also serves an inverse lookup. Given a temperature, the block returns the code of the table entry whose temperature matches exactly. Temperatures outside the table, or between breakpoints, return the error flag. Requests use a valid/ready handshake. Only one request is in flight at a time, and each accepted request produces exactly one single-cycle result pulse.

Top module: `pwl_temp_conv`

## Requirements
- R1: Only the low CODE_W bits of `in_code` are used. Higher bits have no effect, and a successful forward result echoes the masked code on `out_code`.
- R2: Entry i (0..N_ENT-1) has temperature T_FIRST + i*T_STEP and code BASE_CODE ± (i*CODE_STEP + i*i*CODE_CURVE), with minus when DESC=1. A forward result from segment i is temp[i-1] + ((temp[i]-temp[i-1]) * |code[i-1]-c|) / |code[i-1]-code[i]|, with the division truncated toward zero.
- R3: With increasing codes (DESC=0), a code below code[0], equal to code[0], or above the last code returns out_err=1.
- R4: With decreasing codes (DESC=1), a code below the last code, or equal to or above code[0], returns out_err=1. A code equal to the last code returns the last temperature.
- R5: With increasing codes, segment i holds codes in (code[i-1], code[i]]. With decreasing codes, segment i holds codes in [code[i], code[i-1]). A code equal to a breakpoint's code therefore yields that breakpoint's temperature.
- R6: An inverse request (`in_inv`=1) whose temperature equals temp[i] returns out_err=0, out_code=code[i] and out_temp equal to the requested temperature.
- R7: An inverse request whose temperature is below temp[0], above the last temperature, or between breakpoints returns out_err=1.
- R8: After reset `in_ready`=1 and `out_valid`=0. A request is taken when `in_valid` and `in_ready` are both high. `in_ready` then stays low until the result, and each request gives exactly one `out_valid` pulse, during which `in_ready` is high again.
- R9: The result pulse comes no later than $clog2(N_ENT) + IN_W + TEMP_W + 6 clock cycles after the accepting edge.
- R10: When out_err=1, `out_temp` and `out_code` are both zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle, request will be taken |
| in_inv | input | 1 | 0: code to temperature, 1: temperature to code |
| in_code | input | IN_W | Raw sensor code (forward) |
| in_temp | input | TEMP_W | Temperature in millidegrees, signed (inverse) |
| out_valid | output | 1 | One-cycle result pulse |
| out_err | output | 1 | No valid result for the request |
| out_temp | output | TEMP_W | Temperature in millidegrees, signed |
| out_code | output | IN_W | Masked code (forward) or table code (inverse) |

## Verification
A result can arrive at one of three times. A range rejection comes two edges after acceptance. A search miss or an inverse hit comes after at most $clog2(N_ENT)+1 search cycles. A forward hit adds one cycle to start the divider and IN_W+TEMP_W division steps, plus one more to form the output. The bench does not predict the exact cycle. It records the cycle count at acceptance, queues the expected item, and compares it at the falling edge on which `out_valid` is seen. The measured delay is checked against the R9 bound, so early rejections and full divisions go through the same check. Two instances, one with increasing and one with decreasing codes, are run through code sweeps, every breakpoint, both range edges and inverse lookups.

// File: rtl/pwl_pkg.sv
// Shared definitions for the breakpoint converter: controller states and
// the elaboration-time formulas that build each table entry.
// Assumes the code and temperature formulas give a strictly monotonic table.
package pwl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_DIV    = 2'd2,
        ST_FAIL   = 2'd3
    } ctl_state_t;

    // Code of breakpoint idx: quadratic spacing so segments differ in width.
    function automatic int bp_code(input int idx, input int base, input int step,
                                   input int curve, input bit desc);
        int ofs;
        ofs = idx * step + idx * idx * curve;
        return desc ? (base - ofs) : (base + ofs);
    endfunction

    // Temperature of breakpoint idx in millidegrees.
    function automatic int bp_temp(input int idx, input int t_first, input int t_step);
        return t_first + idx * t_step;
    endfunction

endpackage

// File: rtl/pwl_rom.sv
// Breakpoint table with two combinational read ports.
// The table is padded to a power of two. Padding entries read as zero, so an
// out-of-table index never reaches undefined storage.
module pwl_rom #(
    parameter int N_ENT      = 9,
    parameter int CODE_W     = 12,
    parameter int TEMP_W     = 32,
    parameter int IDX_W      = 4,
    parameter int BASE_CODE  = 200,
    parameter int CODE_STEP  = 40,
    parameter int CODE_CURVE = 3,
    parameter bit DESC       = 1'b0,
    parameter int T_FIRST    = -40000,
    parameter int T_STEP     = 5000
) (
    input  logic [IDX_W-1:0]         idx_a,
    input  logic [IDX_W-1:0]         idx_b,
    output logic [CODE_W-1:0]        code_a,
    output logic [CODE_W-1:0]        code_b,
    output logic signed [TEMP_W-1:0] temp_a,
    output logic signed [TEMP_W-1:0] temp_b
);
    localparam int DEPTH = 1 << IDX_W;

    logic [CODE_W-1:0]        code_tab [DEPTH];
    logic signed [TEMP_W-1:0] temp_tab [DEPTH];

    // Fill each slot with its computed breakpoint, or zero past the table end.
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        if (g < N_ENT) begin : g_real
            localparam int C = pwl_pkg::bp_code(g, BASE_CODE, CODE_STEP, CODE_CURVE, DESC);
            localparam int T = pwl_pkg::bp_temp(g, T_FIRST, T_STEP);
            assign code_tab[g] = CODE_W'(C);
            assign temp_tab[g] = TEMP_W'(T);
        end else begin : g_pad
            assign code_tab[g] = '0;
            assign temp_tab[g] = '0;
        end
    end

    // Two independent read ports for the segment's upper and lower ends.
    assign code_a = code_tab[idx_a];
    assign temp_a = temp_tab[idx_a];
    assign code_b = code_tab[idx_b];
    assign temp_b = temp_tab[idx_b];

endmodule

// File: rtl/pwl_div.sv
// Unsigned restoring divider that makes one quotient bit per clock.
// A start pulse loads the operands. done pulses one cycle after the last
// step, with the quotient held until the next start. Assumes den is non-zero.
module pwl_div #(
    parameter int NUM_W = 48,
    parameter int DEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quo
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [DEN_W-1:0] acc;
    logic [DEN_W-1:0] dsr;
    logic [CNT_W-1:0] cnt;
    logic             busy;
    logic [DEN_W:0]   trial;
    logic [DEN_W:0]   diff;

    // Partial remainder shifted by one bit, and the trial subtraction.
    always_comb begin
        trial = {acc, quo[NUM_W-1]};
        diff  = trial - {1'b0, dsr};
    end

    // Load on start, then one restoring step per cycle until the count runs out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc  <= '0;
            dsr  <= '0;
            quo  <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                acc  <= '0;
                dsr  <= den;
                quo  <= num;
                cnt  <= CNT_W'(NUM_W);
                busy <= 1'b1;
            end else if (busy) begin
                if (trial >= {1'b0, dsr}) begin
                    acc <= diff[DEN_W-1:0];
                    quo <= {quo[NUM_W-2:0], 1'b1};
                end else begin
                    acc <= trial[DEN_W-1:0];
                    quo <= {quo[NUM_W-2:0], 1'b0};
                end
                cnt <= cnt - 1'b1;
                if (cnt == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pwl_ctrl.sv
// Request controller: range pre-check, one binary-search probe per clock,
// divider launch for forward hits, and the result register.
// Assumes table temperatures rise with index, codes are monotonic, and
// IN_W >= CODE_W.
module pwl_ctrl
    import pwl_pkg::*;
#(
    parameter int N_ENT     = 9,
    parameter int IN_W      = 16,
    parameter int CODE_W    = 12,
    parameter int TEMP_W    = 32,
    parameter int IDX_W     = 4,
    parameter int NUM_W     = 48,
    parameter bit DESC      = 1'b0,
    parameter int FIRST_CODE = 200,
    parameter int LAST_CODE  = 712,
    parameter int T_FIRST   = -40000,
    parameter int T_LAST    = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic                     in_inv,
    input  logic [IN_W-1:0]          in_code,
    input  logic signed [TEMP_W-1:0] in_temp,
    output logic [IDX_W-1:0]         idx_hi,
    output logic [IDX_W-1:0]         idx_lo,
    input  logic [CODE_W-1:0]        rom_code_hi,
    input  logic [CODE_W-1:0]        rom_code_lo,
    input  logic signed [TEMP_W-1:0] rom_temp_hi,
    input  logic signed [TEMP_W-1:0] rom_temp_lo,
    output logic                     div_start,
    output logic [NUM_W-1:0]         div_num,
    output logic [IN_W-1:0]          div_den,
    input  logic                     div_done,
    input  logic [NUM_W-1:0]         div_quo,
    output logic                     out_valid,
    output logic                     out_err,
    output logic signed [TEMP_W-1:0] out_temp,
    output logic [IN_W-1:0]          out_code
);
    localparam int SW = IDX_W + 2;
    localparam logic [IN_W-1:0]          C_FIRST = IN_W'(FIRST_CODE);
    localparam logic [IN_W-1:0]          C_LAST  = IN_W'(LAST_CODE);
    localparam logic signed [TEMP_W-1:0] TT_LO   = TEMP_W'(T_FIRST);
    localparam logic signed [TEMP_W-1:0] TT_HI   = TEMP_W'(T_LAST);

    ctl_state_t               state;
    logic signed [SW-1:0]     low;
    logic signed [SW-1:0]     high;
    logic signed [SW-1:0]     mid;
    logic signed [SW-1:0]     mid_m1;
    logic [IN_W-1:0]          code_r;
    logic signed [TEMP_W-1:0] temp_r;
    logic                     inv_r;
    logic signed [TEMP_W-1:0] tlo_r;
    logic [IN_W-1:0]          c_hi;
    logic [IN_W-1:0]          c_lo;
    logic                     hit_fwd;
    logic                     up_fwd;
    logic [IN_W-1:0]          dc;
    logic [IN_W-1:0]          den_c;
    logic                     hit;
    logic                     go_up;
    logic                     empty;
    logic                     bad_in;
    logic signed [TEMP_W-1:0] dt;

    assign in_ready = (state == ST_IDLE);

    // Midpoint of the current search window and its lower neighbour.
    always_comb begin
        mid    = (low + high) >>> 1;
        mid_m1 = mid - SW'(1);
        idx_hi = IDX_W'(mid);
        idx_lo = IDX_W'(mid_m1);
        c_hi   = IN_W'(rom_code_hi);
        c_lo   = IN_W'(rom_code_lo);
        empty  = (low > high);
        dt     = rom_temp_hi - rom_temp_lo;
    end

    // Bracket test and search direction chosen by the table's code order.
    if (DESC) begin : g_desc
        assign hit_fwd = (code_r >= c_hi) && (code_r < c_lo);
        assign up_fwd  = (code_r < c_hi);
        assign dc      = c_lo - code_r;
        assign den_c   = c_lo - c_hi;
    end else begin : g_asc
        assign hit_fwd = (code_r <= c_hi) && (code_r > c_lo);
        assign up_fwd  = (code_r > c_hi);
        assign dc      = code_r - c_lo;
        assign den_c   = c_hi - c_lo;
    end

    // Merge forward and inverse probes: inverse matches an exact temperature.
    always_comb begin
        hit   = inv_r ? (temp_r == rom_temp_hi) : hit_fwd;
        go_up = inv_r ? (temp_r > rom_temp_hi) : up_fwd;
    end

    // Early rejection of out-of-range requests before any search.
    always_comb begin
        if (in_inv)
            bad_in = (in_temp < TT_LO) || (in_temp > TT_HI);
        else if (DESC)
            bad_in = (in_code < C_LAST);
        else
            bad_in = (in_code < C_FIRST);
    end

    // Request sequencing, window narrowing and the result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            low       <= '0;
            high      <= '0;
            code_r    <= '0;
            temp_r    <= '0;
            inv_r     <= 1'b0;
            tlo_r     <= '0;
            div_start <= 1'b0;
            div_num   <= '0;
            div_den   <= '0;
            out_valid <= 1'b0;
            out_err   <= 1'b0;
            out_temp  <= '0;
            out_code  <= '0;
        end else begin
            out_valid <= 1'b0;
            div_start <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (in_valid) begin
                        code_r <= in_code;
                        temp_r <= in_temp;
                        inv_r  <= in_inv;
                        low    <= in_inv ? SW'(0) : SW'(1);
                        high   <= SW'(N_ENT - 1);
                        state  <= bad_in ? ST_FAIL : ST_SEARCH;
                    end
                end
                ST_FAIL: begin
                    out_valid <= 1'b1;
                    out_err   <= 1'b1;
                    out_temp  <= '0;
                    out_code  <= '0;
                    state     <= ST_IDLE;
                end
                ST_SEARCH: begin
                    if (empty) begin
                        out_valid <= 1'b1;
                        out_err   <= 1'b1;
                        out_temp  <= '0;
                        out_code  <= '0;
                        state     <= ST_IDLE;
                    end else if (hit && inv_r) begin
                        out_valid <= 1'b1;
                        out_err   <= 1'b0;
                        out_temp  <= temp_r;
                        out_code  <= c_hi;
                        state     <= ST_IDLE;
                    end else if (hit) begin
                        tlo_r     <= rom_temp_lo;
                        div_num   <= NUM_W'($unsigned(dt)) * NUM_W'(dc);
                        div_den   <= den_c;
                        div_start <= 1'b1;
                        state     <= ST_DIV;
                    end else if (go_up) begin
                        low <= mid + SW'(1);
                    end else begin
                        high <= mid_m1;
                    end
                end
                ST_DIV: begin
                    if (div_done) begin
                        out_valid <= 1'b1;
                        out_err   <= 1'b0;
                        out_temp  <= tlo_r + $signed(TEMP_W'(div_quo));
                        out_code  <= code_r;
                        state     <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pwl_temp_conv.sv
// Top of the breakpoint converter: masks the incoming code and connects the
// table, the search controller and the divider.
// Assumes one request in flight. The caller holds in_valid until in_ready.
module pwl_temp_conv #(
    parameter int IN_W       = 16,
    parameter int CODE_W     = 12,
    parameter int TEMP_W     = 32,
    parameter int N_ENT      = 9,
    parameter bit DESC       = 1'b0,
    parameter int BASE_CODE  = 200,
    parameter int CODE_STEP  = 40,
    parameter int CODE_CURVE = 3,
    parameter int T_FIRST    = -40000,
    parameter int T_STEP     = 5000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic                     in_inv,
    input  logic [IN_W-1:0]          in_code,
    input  logic signed [TEMP_W-1:0] in_temp,
    output logic                     out_valid,
    output logic                     out_err,
    output logic signed [TEMP_W-1:0] out_temp,
    output logic [IN_W-1:0]          out_code
);
    localparam int IDX_W = $clog2(N_ENT);
    localparam int NUM_W = IN_W + TEMP_W;
    localparam int FIRST_CODE = pwl_pkg::bp_code(0, BASE_CODE, CODE_STEP, CODE_CURVE, DESC);
    localparam int LAST_CODE  = pwl_pkg::bp_code(N_ENT - 1, BASE_CODE, CODE_STEP, CODE_CURVE, DESC);
    localparam int T_LAST     = pwl_pkg::bp_temp(N_ENT - 1, T_FIRST, T_STEP);
    localparam logic [IN_W-1:0] CODE_MASK = IN_W'((64'd1 << CODE_W) - 64'd1);

    logic [IN_W-1:0]          code_m;
    logic [IDX_W-1:0]         idx_hi;
    logic [IDX_W-1:0]         idx_lo;
    logic [CODE_W-1:0]        rc_hi;
    logic [CODE_W-1:0]        rc_lo;
    logic signed [TEMP_W-1:0] rt_hi;
    logic signed [TEMP_W-1:0] rt_lo;
    logic                     d_start;
    logic [NUM_W-1:0]         d_num;
    logic [IN_W-1:0]          d_den;
    logic                     d_done;
    logic [NUM_W-1:0]         d_quo;

    // Drop bits above the sensor's data width.
    assign code_m = in_code & CODE_MASK;

    pwl_rom #(
        .N_ENT(N_ENT), .CODE_W(CODE_W), .TEMP_W(TEMP_W), .IDX_W(IDX_W),
        .BASE_CODE(BASE_CODE), .CODE_STEP(CODE_STEP), .CODE_CURVE(CODE_CURVE),
        .DESC(DESC), .T_FIRST(T_FIRST), .T_STEP(T_STEP)
    ) rom_i (
        .idx_a(idx_hi), .idx_b(idx_lo),
        .code_a(rc_hi), .code_b(rc_lo),
        .temp_a(rt_hi), .temp_b(rt_lo)
    );

    pwl_ctrl #(
        .N_ENT(N_ENT), .IN_W(IN_W), .CODE_W(CODE_W), .TEMP_W(TEMP_W),
        .IDX_W(IDX_W), .NUM_W(NUM_W), .DESC(DESC),
        .FIRST_CODE(FIRST_CODE), .LAST_CODE(LAST_CODE),
        .T_FIRST(T_FIRST), .T_LAST(T_LAST)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_inv(in_inv),
        .in_code(code_m), .in_temp(in_temp),
        .idx_hi(idx_hi), .idx_lo(idx_lo),
        .rom_code_hi(rc_hi), .rom_code_lo(rc_lo),
        .rom_temp_hi(rt_hi), .rom_temp_lo(rt_lo),
        .div_start(d_start), .div_num(d_num), .div_den(d_den),
        .div_done(d_done), .div_quo(d_quo),
        .out_valid(out_valid), .out_err(out_err),
        .out_temp(out_temp), .out_code(out_code)
    );

    pwl_div #(
        .NUM_W(NUM_W), .DEN_W(IN_W)
    ) div_i (
        .clk(clk), .rst_n(rst_n), .start(d_start),
        .num(d_num), .den(d_den), .done(d_done), .quo(d_quo)
    );

endmodule

// File: rtl/pwl_temp_conv_chk.sv
// Protocol and result-shape properties of the converter, bound to its top.
// Watches ports only. The busy window is measured with a local counter.
module pwl_temp_conv_chk #(
    parameter int IN_W    = 16,
    parameter int CODE_W  = 12,
    parameter int TEMP_W  = 32,
    parameter int N_ENT   = 9,
    parameter int T_FIRST = -40000,
    parameter int T_STEP  = 5000
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic                     in_ready,
    input logic                     in_inv,
    input logic                     out_valid,
    input logic                     out_err,
    input logic signed [TEMP_W-1:0] out_temp,
    input logic [IN_W-1:0]          out_code
);
    localparam int BUSY_MAX = $clog2(N_ENT) + IN_W + TEMP_W + 6;
    localparam int T_LAST   = T_FIRST + (N_ENT - 1) * T_STEP;
    localparam logic [IN_W-1:0] CODE_LIM = IN_W'((64'd1 << CODE_W) - 64'd1);

    logic [15:0] busy_cnt;
    logic        inv_q;

    // Length of the current busy window, and the kind of request in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= '0;
            inv_q    <= 1'b0;
        end else begin
            busy_cnt <= in_ready ? 16'd0 : busy_cnt + 16'd1;
            if (in_valid && in_ready) inv_q <= in_inv;
        end
    end

    // R8
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);
    // R8
    result_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_ready);
    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    // R10
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> (out_temp == '0 && out_code == '0));
    // R9
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (busy_cnt < 16'(BUSY_MAX)));
    // R2
    temp_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err && !inv_q) |-> (out_temp >= T_FIRST && out_temp <= T_LAST));
    // R1
    code_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err && !inv_q) |-> (out_code <= CODE_LIM));

endmodule

bind pwl_temp_conv pwl_temp_conv_chk #(
    .IN_W(IN_W), .CODE_W(CODE_W), .TEMP_W(TEMP_W),
    .N_ENT(N_ENT), .T_FIRST(T_FIRST), .T_STEP(T_STEP)
) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_inv(in_inv), .out_valid(out_valid), .out_err(out_err),
    .out_temp(out_temp), .out_code(out_code)
);

// File: tb/pwl_temp_conv_tb_top.sv
// Scoreboard bench: one instance with rising codes, one with falling codes.
module pwl_temp_conv_tb_top;
    localparam int N       = 9;
    localparam int IN_W    = 16;
    localparam int TEMP_W  = 32;
    localparam int LAT_MAX = $clog2(N) + IN_W + TEMP_W + 6;

    typedef struct {
        bit    err;
        int    temp;
        int    code;
        int    acc;
        string req;
    } item_t;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                     rst_n = 1'b0;
    logic                     vi = 1'b0;
    logic                     vd = 1'b0;
    logic                     inv = 1'b0;
    logic [IN_W-1:0]          code = '0;
    logic signed [TEMP_W-1:0] temp = '0;
    logic                     rdy_i, rdy_d, ov_i, ov_d, oe_i, oe_d;
    logic signed [TEMP_W-1:0] ot_i, ot_d;
    logic [IN_W-1:0]          oc_i, oc_d;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    item_t q_inc[$];
    item_t q_dec[$];

    always @(posedge clk) cyc <= cyc + 1;

    pwl_temp_conv #(.DESC(1'b0), .BASE_CODE(200)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(vi), .in_ready(rdy_i), .in_inv(inv),
        .in_code(code), .in_temp(temp), .out_valid(ov_i), .out_err(oe_i),
        .out_temp(ot_i), .out_code(oc_i));

    pwl_temp_conv #(.DESC(1'b1), .BASE_CODE(3800)) dut_dec (
        .clk(clk), .rst_n(rst_n), .in_valid(vd), .in_ready(rdy_d), .in_inv(inv),
        .in_code(code), .in_temp(temp), .out_valid(ov_d), .out_err(oe_d),
        .out_temp(ot_d), .out_code(oc_d));

    function automatic int tb_code(bit d, int i);
        int o = i * 40 + i * i * 3;
        return d ? 3800 - o : 200 + o;
    endfunction

    function automatic int tb_temp(int i);
        return -40000 + i * 5000;
    endfunction

    // Forward model: linear scan over the half-open segments (R2, R5).
    function automatic item_t model_fwd(bit d, logic [IN_W-1:0] raw);
        item_t it;
        int c = int'(raw & 16'h0FFF);
        it.err = 1'b1; it.temp = 0; it.code = 0; it.acc = 0; it.req = "";
        for (int i = 1; i < N; i++) begin
            int lo = tb_code(d, i - 1);
            int hi = tb_code(d, i);
            bit in_seg = d ? (c >= hi && c < lo) : (c <= hi && c > lo);
            if (in_seg && it.err) begin
                longint num = longint'(tb_temp(i) - tb_temp(i - 1)) * longint'(d ? lo - c : c - lo);
                longint den = longint'(d ? lo - hi : hi - lo);
                it.err  = 1'b0;
                it.temp = tb_temp(i - 1) + int'(num / den);
                it.code = c;
            end
        end
        return it;
    endfunction

    // Inverse model: exact temperature match only (R6, R7).
    function automatic item_t model_inv(bit d, int t);
        item_t it;
        it.err = 1'b1; it.temp = 0; it.code = 0; it.acc = 0; it.req = "";
        for (int i = 0; i < N; i++) begin
            if (t == tb_temp(i)) begin
                it.err = 1'b0; it.temp = t; it.code = tb_code(d, i);
            end
        end
        return it;
    endfunction

    task automatic check_eq(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_item(item_t it, logic e, int t, logic [IN_W-1:0] c);
        check_eq(it.req, "err", longint'(e), longint'(it.err));
        check_eq(it.req, "temp", longint'(t), longint'(it.temp));
        check_eq(it.req, "code", longint'(c), longint'(it.code));
        n_chk++;
        if (cyc - it.acc > LAT_MAX) begin
            n_fail++;
            $display("FAIL R9 latency (%s): actual %0d expected <= %0d", it.req, cyc - it.acc, LAT_MAX);
        end
    endtask

    // Monitors: compare each result pulse with the oldest queued item.
    always @(negedge clk) begin
        if (rst_n && ov_i) begin
            if (q_inc.size() == 0) check_eq("R8", "unexpected result rising", 1, 0);
            else check_item(q_inc.pop_front(), oe_i, ot_i, oc_i);
        end
        if (rst_n && ov_d) begin
            if (q_dec.size() == 0) check_eq("R8", "unexpected result falling", 1, 0);
            else check_item(q_dec.pop_front(), oe_d, ot_d, oc_d);
        end
    end

    // Driver: wait for idle, present one request for one cycle, queue the model.
    task automatic send(bit d, bit iv, logic [IN_W-1:0] c, int t, string req);
        item_t it;
        @(negedge clk);
        while (!(rdy_i && rdy_d)) @(negedge clk);
        inv = iv; code = c; temp = t;
        if (d) vd = 1'b1; else vi = 1'b1;
        it = iv ? model_inv(d, t) : model_fwd(d, c);
        it.req = req;
        it.acc = cyc;
        if (d) q_dec.push_back(it); else q_inc.push_back(it);
        @(negedge clk);
        vi = 1'b0; vd = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check_eq("R9", "watchdog expired", 1, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R8 reset state
        check_eq("R8", "reset in_ready rising", longint'(rdy_i), 1);
        check_eq("R8", "reset in_ready falling", longint'(rdy_d), 1);
        check_eq("R8", "reset out_valid", longint'(ov_i | ov_d), 0);
        rst_n = 1'b1;

        // Rising table corners
        send(0, 0, 16'd199, 0, "R3 below first");
        send(0, 0, 16'd200, 0, "R3 equal first");
        send(0, 0, 16'd713, 0, "R3 above last");
        send(0, 0, 16'd201, 0, "R2 just above first");
        send(0, 0, 16'd243, 0, "R5 breakpoint 1");
        send(0, 0, 16'd712, 0, "R5 last breakpoint");
        send(0, 0, 16'hF000 | 16'd300, 0, "R1 upper bits masked");
        send(0, 0, 16'h0FFF, 0, "R3 max code");
        for (int c = 190; c <= 720; c += 3) send(0, 0, 16'(c), 0, "R2 rising sweep");
        for (int i = 0; i < N; i++) send(0, 1, 16'h0, tb_temp(i), "R6 rising inverse");
        send(0, 1, 16'h0, -40001, "R7 inverse below");
        send(0, 1, 16'h0, 1, "R7 inverse above");
        send(0, 1, 16'h0, -37500, "R7 inverse between");

        // Falling table corners
        send(1, 0, 16'd3287, 0, "R4 below last");
        send(1, 0, 16'd3288, 0, "R4 equal last");
        send(1, 0, 16'd3800, 0, "R4 equal first");
        send(1, 0, 16'd3900, 0, "R4 above first");
        send(1, 0, 16'd3799, 0, "R2 just below first");
        send(1, 0, 16'd3757, 0, "R5 falling breakpoint 1");
        send(1, 0, 16'hA000 | 16'd3500, 0, "R1 falling masked");
        for (int c = 3280; c <= 3810; c += 3) send(1, 0, 16'(c), 0, "R2 falling sweep");
        for (int i = 0; i < N; i++) send(1, 1, 16'h0, tb_temp(i), "R6 falling inverse");
        send(1, 1, 16'h0, -45000, "R7 falling inverse below");
        send(1, 1, 16'h0, -12345, "R7 falling inverse between");

        repeat (LAT_MAX + 4) @(negedge clk);
        check_eq("R8", "pending rising", q_inc.size(), 0);
        check_eq("R8", "pending falling", q_dec.size(), 0);
        // R10 error outputs are compared as zero in every queued error item
        summary();
        $finish;
    end

endmodule